// File: doc/BRIEF.md
# Character Terminal Control Interpreter

This block sits between a byte source (a processor port or a serial receiver) and the character memory of an 80-column, 40-row text display. Bytes arrive one at a time on a write strobe; the block accepts a byte on any clock edge where it is not busy. Printable bytes are stored at the cursor cell together with the current text attribute, and the cursor then advances. Carriage return and line feed move the cursor. An escape byte starts a control sequence.

Control sequences come in two kinds. Bare ones are an escape followed by a single byte: reset the screen, save the cursor, restore the cursor. Bracketed ones are an escape, a `[`, up to two decimal parameters separated by `;`, and a final letter. The final letter selects a relative move, an absolute move, an erase or an attribute change. Erases are carried out as a run of writes to the memory port, one cell per clock, and busy stays high for the whole run.

The block also divides a cursor-blink tick to give the phase used for blinking text. Pixel timing, the glyph store (8 by 12 pixels per cell) and scrolling belong to neighbouring blocks.

Top module: `term_esc_core`

## Requirements
- R1: After reset the cursor is at row 0 column 0, the attribute is 0, busy is low, the memory write strobe is low and the blink phase is 0.
- R2: A byte from 0x20 to 0x7E accepted in normal mode produces, on the next clock, a memory write at address row*80+column with that byte and the current attribute. The column then advances; after column 79 it becomes 0 and the row increments, stopping at row 39.
- R3: Carriage return (0x0D) sets the column to 0. Line feed (0x0A) increments the row, stopping at row 39.
- R4: ESC [ n A, B, C and D move the cursor up, down, right and left by n cells and stop at the screen edge. A parameter of 0, or a missing one, moves by one cell.
- R5: ESC [ r ; c H (or f) places the cursor at 1-based row r and column c, where 0 or missing counts as 1. With wrap_mode_i low the result is clamped to row 39 and column 79. With wrap_mode_i high, row r-1 is taken modulo 40 and column c-1 modulo 80.
- R6: ESC [ n J writes the blank 0x20 with the current attribute to ascending addresses, one per clock, while busy is high. With n of 0 or missing, the range runs from the cursor cell to 3199. With n of 1, it runs from 0 to the cursor cell. In both of these cases the cursor is unchanged. With n of 2 or 3 the whole screen is written and the cursor goes to 0,0.
- R7: ESC c behaves exactly like ESC [ 3 J.
- R8: ESC 7 saves the cursor position and the attribute. ESC 8 restores both.
- R9: ESC [ n m changes the attribute, applying up to two parameters in order. The codes are: 0 clears all bits, 1 sets bit 0 (bold), 7 sets bit 1 (reverse), 5 sets bit 2 (blink), and 30 to 37 set bits 5:3 to n-30. Setting a bit leaves the other bits unchanged.
- R10: An unknown byte after ESC, or an unknown final byte in a bracketed sequence (including ESC [ 6 n), changes neither the cursor nor the attribute. The byte after it is handled in normal mode.
- R11: blink_phase_o toggles once for every four clocks on which blink_tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Byte strobe, taken when busy_o is low |
| data_i | input | 8 | Incoming byte |
| wrap_mode_i | input | 1 | Absolute positioning: 0 clamps, 1 wraps |
| blink_tick_i | input | 1 | One-clock pulse from the cursor blink timer |
| busy_o | output | 1 | High while an erase run is in progress |
| mem_we_o | output | 1 | Character memory write strobe |
| mem_addr_o | output | 12 | Cell address, row*80+column |
| mem_char_o | output | 8 | Character code to store |
| mem_attr_o | output | 8 | Attribute to store |
| cursor_col_o | output | 7 | Cursor column |
| cursor_row_o | output | 6 | Cursor row |
| attr_o | output | 8 | Current attribute |
| blink_phase_o | output | 1 | Blink phase for text with the blink bit set |

## Verification
A parser left in the wrong state shows up on the first byte that follows. Either a printable byte produces no write, or a letter moves the cursor, and both are visible within one clock on the memory port or the cursor outputs. Errors in the cursor arithmetic show up as a wrong cell address on the next printable write. The bench drives every edge, clamp and wrap case to the position it expects. A faulty erase sequencer shows up as a missing, repeated or out-of-order address in the write stream during the run. The scoreboard compares every write of each run in order, so the first bad cell is reported in the cycle it appears.

// File: rtl/term_pkg.sv
package term_pkg;

  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_ESC  = 2'd1,
    ST_CSI  = 2'd2
  } parse_st_e;

  localparam logic [7:0] CH_CR    = 8'h0D;
  localparam logic [7:0] CH_LF    = 8'h0A;
  localparam logic [7:0] CH_ESC   = 8'h1B;
  localparam logic [7:0] CH_BLANK = 8'h20;

  localparam int ATTR_BOLD  = 0;
  localparam int ATTR_REV   = 1;
  localparam int ATTR_BLINK = 2;

  // Attribute update for one select-graphic code; unknown codes leave it alone.
  function automatic logic [7:0] sgr_apply(input logic [7:0] a, input int n);
    logic [7:0] r;
    r = a;
    if (n == 0) r = '0;
    else if (n == 1) r[ATTR_BOLD] = 1'b1;
    else if (n == 5) r[ATTR_BLINK] = 1'b1;
    else if (n == 7) r[ATTR_REV] = 1'b1;
    else if (n >= 30 && n <= 37) r[5:3] = 3'(n - 30);
    return r;
  endfunction

endpackage

// File: rtl/term_param_acc.sv
module term_param_acc #(
  parameter int PARAM_W = 8,
  parameter int NPARAM  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            clr_i,
  input  logic                            dig_i,
  input  logic [3:0]                      dig_val_i,
  input  logic                            sep_i,
  output logic [NPARAM-1:0][PARAM_W-1:0]  val_o,
  output logic [NPARAM-1:0]               has_o
);
  localparam int SEL_W = (NPARAM > 1) ? $clog2(NPARAM) : 1;
  localparam int PMAX  = (1 << PARAM_W) - 1;

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (clr_i) sel_q <= '0;
    else if (sep_i && int'(sel_q) < NPARAM - 1) sel_q <= sel_q + 1'b1;
  end

  for (genvar g = 0; g < NPARAM; g++) begin : g_par
    int nxt;
    always_comb begin
      nxt = int'(val_o[g]) * 10 + int'(dig_val_i);
      if (nxt > PMAX) nxt = PMAX;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_o[g] <= '0;
        has_o[g] <= 1'b0;
      end else if (clr_i) begin
        val_o[g] <= '0;
        has_o[g] <= 1'b0;
      end else if (dig_i && sel_q == SEL_W'(g)) begin
        val_o[g] <= PARAM_W'(nxt);
        has_o[g] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/term_erase_seq.sv
module term_erase_seq #(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              active_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      addr_o   <= '0;
      hi_q     <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      addr_o   <= lo_i;
      hi_q     <= hi_i;
    end else if (active_o) begin
      if (addr_o == hi_q) active_o <= 1'b0;
      else addr_o <= addr_o + 1'b1;
    end
  end

  AST_ERASE_ASCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !start_i) |=> (!active_o || addr_o == $past(addr_o) + 1'b1)) // R6
    else $error("erase address not ascending");

endmodule

// File: rtl/term_blink_div.sv
module term_blink_div #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic phase_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_o <= 1'b0;
    end else if (tick_i) begin
      if (int'(cnt_q) == DIV - 1) begin
        cnt_q   <= '0;
        phase_o <= ~phase_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_BLINK_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(phase_o)) // R11
    else $error("blink phase moved without tick");

endmodule

// File: rtl/term_esc_core.sv
module term_esc_core
  import term_pkg::*;
#(
  parameter int COLS      = 80,
  parameter int ROWS      = 40,
  parameter int PARAM_W   = 8,
  parameter int BLINK_DIV = 4,
  localparam int CELLS    = COLS * ROWS,
  localparam int ADDR_W   = $clog2(CELLS),
  localparam int COL_W    = $clog2(COLS),
  localparam int ROW_W    = $clog2(ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        data_i,
  input  logic              wrap_mode_i,
  input  logic              blink_tick_i,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_char_o,
  output logic [7:0]        mem_attr_o,
  output logic [COL_W-1:0]  cursor_col_o,
  output logic [ROW_W-1:0]  cursor_row_o,
  output logic [7:0]        attr_o,
  output logic              blink_phase_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(CELLS - 1);

  parse_st_e st_q, st_d;
  logic [COL_W-1:0]  col_q, col_d, sv_col_q, sv_col_d;
  logic [ROW_W-1:0]  row_q, row_d, sv_row_q, sv_row_d;
  logic [7:0]        attr_q, attr_d, sv_attr_q, sv_attr_d;
  logic              pw_q, pw_d;
  logic [ADDR_W-1:0] pa_q, pa_d;
  logic [7:0]        pc_q, pc_d, pat_q, pat_d;

  logic              acc, is_digit, dig_v, sep_v, clr_v;
  logic [ADDR_W-1:0] cur_addr;
  logic              er_start, er_active;
  logic [ADDR_W-1:0] er_lo, er_hi, er_addr;

  logic [1:0][PARAM_W-1:0] pval;
  logic [1:0]              phas;

  int mv, mv2, rz, cz, abs_r, abs_c;

  assign acc      = wr_i && !busy_o;
  assign is_digit = (data_i >= "0") && (data_i <= "9");
  assign dig_v    = acc && (st_q == ST_CSI) && is_digit;
  assign sep_v    = acc && (st_q == ST_CSI) && (data_i == ";");
  assign clr_v    = acc && (st_q == ST_ESC) && (data_i == "[");
  assign cur_addr = ADDR_W'(row_q) * ADDR_W'(COLS) + ADDR_W'(col_q);

  term_param_acc #(.PARAM_W(PARAM_W), .NPARAM(2)) u_par (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_v),
    .dig_i     (dig_v),
    .dig_val_i (data_i[3:0]),
    .sep_i     (sep_v),
    .val_o     (pval),
    .has_o     (phas)
  );

  term_erase_seq #(.ADDR_W(ADDR_W)) u_erase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (er_start),
    .lo_i     (er_lo),
    .hi_i     (er_hi),
    .active_o (er_active),
    .addr_o   (er_addr)
  );

  term_blink_div #(.DIV(BLINK_DIV)) u_blink (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (blink_tick_i),
    .phase_o (blink_phase_o)
  );

  // Parameter interpretation: zero or absent counts as one for moves.
  always_comb begin
    mv  = (phas[0] && pval[0] != '0) ? int'(pval[0]) : 1;
    mv2 = (phas[1] && pval[1] != '0) ? int'(pval[1]) : 1;
    rz  = mv - 1;
    cz  = mv2 - 1;
    if (wrap_mode_i) begin
      abs_r = rz % ROWS;
      abs_c = cz % COLS;
    end else begin
      abs_r = (rz > ROWS - 1) ? ROWS - 1 : rz;
      abs_c = (cz > COLS - 1) ? COLS - 1 : cz;
    end
  end

  always_comb begin
    st_d     = st_q;
    col_d    = col_q;
    row_d    = row_q;
    attr_d   = attr_q;
    sv_col_d = sv_col_q;
    sv_row_d = sv_row_q;
    sv_attr_d = sv_attr_q;
    pw_d     = 1'b0;
    pa_d     = pa_q;
    pc_d     = pc_q;
    pat_d    = pat_q;
    er_start = 1'b0;
    er_lo    = '0;
    er_hi    = LAST;
    if (acc) begin
      unique case (st_q)
        ST_NORM: begin
          if (data_i >= 8'h20 && data_i <= 8'h7E) begin
            pw_d  = 1'b1;
            pa_d  = cur_addr;
            pc_d  = data_i;
            pat_d = attr_q;
            if (int'(col_q) == COLS - 1) begin
              col_d = '0;
              if (int'(row_q) < ROWS - 1) row_d = row_q + 1'b1;
            end else begin
              col_d = col_q + 1'b1;
            end
          end else if (data_i == CH_CR) begin
            col_d = '0;
          end else if (data_i == CH_LF) begin
            if (int'(row_q) < ROWS - 1) row_d = row_q + 1'b1;
          end else if (data_i == CH_ESC) begin
            st_d = ST_ESC;
          end
        end
        ST_ESC: begin
          st_d = ST_NORM;
          case (data_i)
            "[": st_d = ST_CSI;
            "c": begin
              er_start = 1'b1;
              col_d    = '0;
              row_d    = '0;
            end
            "7": begin
              sv_col_d  = col_q;
              sv_row_d  = row_q;
              sv_attr_d = attr_q;
            end
            "8": begin
              col_d  = sv_col_q;
              row_d  = sv_row_q;
              attr_d = sv_attr_q;
            end
            default: ;
          endcase
        end
        ST_CSI: begin
          if (!is_digit && data_i != ";") begin
            st_d = ST_NORM;
            case (data_i)
              "A": row_d = ROW_W'((int'(row_q) > mv) ? int'(row_q) - mv : 0);
              "B": row_d = ROW_W'((int'(row_q) + mv > ROWS - 1) ? ROWS - 1 : int'(row_q) + mv);
              "C": col_d = COL_W'((int'(col_q) + mv > COLS - 1) ? COLS - 1 : int'(col_q) + mv);
              "D": col_d = COL_W'((int'(col_q) > mv) ? int'(col_q) - mv : 0);
              "H", "f": begin
                row_d = ROW_W'(abs_r);
                col_d = COL_W'(abs_c);
              end
              "J": begin
                case (int'(pval[0]))
                  0: begin
                    er_start = 1'b1;
                    er_lo    = cur_addr;
                  end
                  1: begin
                    er_start = 1'b1;
                    er_hi    = cur_addr;
                  end
                  2, 3: begin
                    er_start = 1'b1;
                    col_d    = '0;
                    row_d    = '0;
                  end
                  default: ;
                endcase
              end
              "m": attr_d = phas[1] ? sgr_apply(sgr_apply(attr_q, int'(pval[0])), int'(pval[1]))
                                    : sgr_apply(attr_q, int'(pval[0]));
              default: ;
            endcase
          end
        end
        default: st_d = ST_NORM;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_NORM;
      col_q     <= '0;
      row_q     <= '0;
      attr_q    <= '0;
      sv_col_q  <= '0;
      sv_row_q  <= '0;
      sv_attr_q <= '0;
      pw_q      <= 1'b0;
      pa_q      <= '0;
      pc_q      <= '0;
      pat_q     <= '0;
    end else begin
      st_q      <= st_d;
      col_q     <= col_d;
      row_q     <= row_d;
      attr_q    <= attr_d;
      sv_col_q  <= sv_col_d;
      sv_row_q  <= sv_row_d;
      sv_attr_q <= sv_attr_d;
      pw_q      <= pw_d;
      pa_q      <= pa_d;
      pc_q      <= pc_d;
      pat_q     <= pat_d;
    end
  end

  assign busy_o       = er_active;
  assign mem_we_o     = er_active | pw_q;
  assign mem_addr_o   = er_active ? er_addr : pa_q;
  assign mem_char_o   = er_active ? CH_BLANK : pc_q;
  assign mem_attr_o   = er_active ? attr_q : pat_q;
  assign cursor_col_o = col_q;
  assign cursor_row_o = row_q;
  assign attr_o       = attr_q;

  AST_CURSOR_BOUNDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(cursor_col_o) < COLS) && (int'(cursor_row_o) < ROWS)) // R2
    else $error("cursor outside grid");

  AST_BUSY_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(cursor_col_o) && $stable(cursor_row_o) && $stable(attr_o))) // R6
    else $error("cursor or attribute moved during erase");

endmodule

// File: tb/term_esc_core_bench.sv
module term_esc_core_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    addr;
    int    ch;
    int    at;
    string tag;
  } wr_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       wrap_mode_i = 1'b0;
  logic       blink_tick_i = 1'b0;
  logic       busy_o, mem_we_o, blink_phase_o;
  logic [11:0] mem_addr_o;
  logic [7:0] mem_char_o, mem_attr_o, attr_o;
  logic [6:0] cursor_col_o;
  logic [5:0] cursor_row_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;
  wr_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  term_esc_core u_term_esc_core (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .wr_i          (wr_i),
    .data_i        (data_i),
    .wrap_mode_i   (wrap_mode_i),
    .blink_tick_i  (blink_tick_i),
    .busy_o        (busy_o),
    .mem_we_o      (mem_we_o),
    .mem_addr_o    (mem_addr_o),
    .mem_char_o    (mem_char_o),
    .mem_attr_o    (mem_attr_o),
    .cursor_col_o  (cursor_col_o),
    .cursor_row_o  (cursor_row_o),
    .attr_o        (attr_o),
    .blink_phase_o (blink_phase_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: every write on the memory port is matched against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && mem_we_o) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL unexpected write actual=%0d expected=none", mem_addr_o);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk(e.tag, "write addr", int'(mem_addr_o), e.addr);
        chk(e.tag, "write char", int'(mem_char_o), e.ch);
        chk(e.tag, "write attr", int'(mem_attr_o), e.at);
      end
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    wr_i = 1'b1;
    data_i = b;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic csi(input string s);
    send(8'h1B);
    send("[");
    for (int i = 0; i < s.len(); i++) send(s[i]);
  endtask

  task automatic put(input string tag, input logic [7:0] ch, input int addr, input int at);
    exp_q.push_back('{addr, int'(ch), at, tag});
    send(ch);
  endtask

  task automatic push_erase(input string tag, input int lo, input int hi, input int at);
    for (int a = lo; a <= hi; a++) exp_q.push_back('{a, 32, at, tag});
  endtask

  task automatic cur(input string tag, input int r, input int c);
    chk(tag, "row", int'(cursor_row_o), r);
    chk(tag, "col", int'(cursor_col_o), c);
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
    blink_tick_i = 1'b1;
    @(negedge clk);
    blink_tick_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cur("R1", 0, 0);
    chk("R1", "attr", int'(attr_o), 0);
    chk("R1", "busy", int'(busy_o), 0);
    chk("R1", "we", int'(mem_we_o), 0);
    chk("R1", "blink", int'(blink_phase_o), 0);

    // R2 printable writes and line wrap
    put("R2", "A", 0, 0);
    put("R2", "B", 1, 0);
    cur("R2", 0, 2);
    csi("5;78H");
    cur("R5", 4, 77);
    put("R2", "X", 397, 0);
    put("R2", "Y", 398, 0);
    put("R2", "Z", 399, 0);
    cur("R2", 5, 0);

    // R3 CR and LF
    put("R3", "W", 400, 0);
    send(8'h0D);
    cur("R3", 5, 0);
    send(8'h0A);
    cur("R3", 6, 0);
    csi("40;1H");
    send(8'h0A);
    cur("R3", 39, 0);

    // R4 relative moves
    csi("10;10H");
    cur("R5", 9, 9);
    csi("0A");  cur("R4", 8, 9);
    csi("A");   cur("R4", 7, 9);
    csi("3B");  cur("R4", 10, 9);
    csi("C");   cur("R4", 10, 10);
    csi("5D");  cur("R4", 10, 5);
    csi("99D"); cur("R4", 10, 0);
    csi("99A"); cur("R4", 0, 0);
    csi("99B"); cur("R4", 39, 0);
    csi("99C"); cur("R4", 39, 79);

    // R5 clamp vs wrap
    csi("45;3H");
    cur("R5", 39, 2);
    wrap_mode_i = 1'b1;
    csi("45;85H");  cur("R5", 4, 4);
    csi("H");       cur("R5", 0, 0);
    csi("80;160f"); cur("R5", 39, 79);
    wrap_mode_i = 1'b0;

    // R9 attributes
    csi("1m"); chk("R9", "attr", int'(attr_o), 1);
    csi("5m"); chk("R9", "attr", int'(attr_o), 5);
    csi("7;32m"); chk("R9", "attr", int'(attr_o), 23);
    csi("1;1H");
    put("R9", "k", 0, 23);
    csi("0m"); chk("R9", "attr", int'(attr_o), 0);
    csi("1m");

    // R8 save and restore
    csi("3;4H");
    send(8'h1B); send("7");
    csi("1;1H");
    csi("0m");
    send(8'h1B); send("8");
    cur("R8", 2, 3);
    chk("R8", "attr", int'(attr_o), 1);

    // R10 aborts
    send(8'h1B); send("x");
    cur("R10", 2, 3);
    put("R10", "a", 163, 1);
    csi("5z");
    cur("R10", 2, 4);
    chk("R10", "attr", int'(attr_o), 1);
    put("R10", "b", 164, 1);
    csi("6n");
    cur("R10", 2, 5);

    // R6 erase variants
    csi("40;71H");
    push_erase("R6", 3190, 3199, 1);
    csi("J");
    chk("R6", "busy", int'(busy_o), 1);
    drain();
    cur("R6", 39, 70);
    csi("1;6H");
    push_erase("R6", 0, 5, 1);
    csi("1J");
    drain();
    cur("R6", 0, 5);
    csi("8;9H");
    push_erase("R6", 0, 3199, 1);
    csi("2J");
    cur("R6", 0, 0);
    drain();
    chk("R6", "busy", int'(busy_o), 0);

    // R7 bare reset
    csi("8;8H");
    push_erase("R7", 0, 3199, 1);
    send(8'h1B); send("c");
    chk("R7", "busy", int'(busy_o), 1);
    cur("R7", 0, 0);
    drain();

    // R11 blink divider
    tick(); tick(); tick();
    chk("R11", "phase", int'(blink_phase_o), 0);
    tick();
    chk("R11", "phase", int'(blink_phase_o), 1);
    repeat (4) tick();
    chk("R11", "phase", int'(blink_phase_o), 0);

    drain();
    chk("R2", "scoreboard empty", exp_q.size(), 0);
    done = 1;
    finish_run();
  end

endmodule